// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Engine

This block runs complete command framings on a three-wire serial EEPROM (select, serial clock, data to the device, data from the device) for a simple host command port. The host presents one of four operations (read a word, write a word, enable writes, disable writes) together with an 8-bit word address, 16-bit write data and a poll limit, and pulses `cmd_valid`. The engine then produces the whole pin sequence by itself and signals completion with a one-cycle `done`, along with read data and an error flag.

Every bit sent to the device takes three equal phases under select: the data is set up with the clock low, the clock goes high, and then the clock goes low again. Each phase lasts `PHASE_CLKS` system clocks. A word write is run as a sequence: enable frame, write frame, ready poll, disable frame. Select drops for one phase between frames. During the ready poll the device signals ready by driving its data line high. If that does not happen within the programmed number of samples, the write ends with an error.

Top module: `uwire_eeprom_master`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `mw_sel`, `mw_clk`, `mw_tx`, `busy`, `done` and `err` are low and `rdata` is zero.
- R2: In idle, a `cmd_valid` sampled at a clock edge is accepted. `busy` is high from the next cycle until the cycle in which `done` pulses high for exactly one cycle, and `busy` is low in that cycle. A `cmd_valid` seen while `busy` is high is ignored and produces no pin activity and no extra `done`.
- R3: Each bit sent takes three phases of `PHASE_CLKS` cycles each: data valid with clock low, clock high, clock low. The most significant bit goes first. Every clock-high interval lasts exactly `PHASE_CLKS` cycles, and `mw_clk` is high only while `mw_sel` is high.
- R4: Host opcode `cmd_op` = 2'b00 is a read. It sends the 11 bits 1, 1, 0, addr[7:0], then gives 16 clock pulses with `mw_tx` low and samples `mw_rx` at the end of each clock-high phase. The first sample is bit 15 of `rdata`.
- R5: Host opcode 2'b01 is a write. It runs an enable frame, then the 27-bit frame 1, 0, 1, addr[7:0], data[15:0], then the ready poll, then a disable frame. Select is low for one phase between consecutive frames and after the last one.
- R6: Host opcodes 2'b10 and 2'b11 each send a single 11-bit frame. 2'b10 sends the enable frame 1, 0, 0 followed by eight 1s. 2'b11 sends the disable frame 1 followed by ten 0s. The write sequence uses these same two frames.
- R7: The ready poll holds select high with the clock low and samples `mw_rx` at the end of each phase. The first high sample ends the poll.
- R8: If `poll_limit` consecutive poll samples are all low, the poll ends, and the disable frame is still sent. A limit of 0 acts as 1. `err` rises together with `done` and stays high until the next command is accepted.
- R9: Counted in phases from the accepting edge, `done` is due after 66 phases for a read, 34 for an enable or disable, and 151+k for a write whose poll used k samples.
- R10: `rdata` changes only when a read completes. `err` is cleared when any command is accepted, and it is low at the end of every read, enable, disable or successful write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, accepted when idle |
| cmd_op | input | 2 | 00 read, 01 write, 10 enable writes, 11 disable writes |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Data for a write |
| poll_limit | input | POLL_W | Maximum ready samples after a write |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Ready poll timed out on the last write |
| rdata | output | DATA_W | Data from the last completed read |
| mw_sel | output | 1 | Device chip select |
| mw_clk | output | 1 | Device serial clock |
| mw_tx | output | 1 | Serial data to the device |
| mw_rx | input | 1 | Serial data and ready from the device |

## Verification
Completion time follows directly from the frame lengths: 66 phases for a read, 34 for an enable or disable, and 151 plus the number of poll samples for a write. The bench uses three system clocks per phase. It counts falling clock edges from the edge that accepts a command and expects `done` at exactly phases×3+1. A behavioural device model raises ready after a programmed number of cycles, and the bench converts that number arithmetically into the expected poll sample count. Frames are captured at every select fall and compared bit for bit. Outputs are sampled on the falling edge, away from the edges where the design updates.

// File: rtl/uw_pkg.sv
package uw_pkg;

  // host-side command codes
  localparam logic [1:0] HOST_READ  = 2'b00;
  localparam logic [1:0] HOST_WRITE = 2'b01;
  localparam logic [1:0] HOST_WREN  = 2'b10;
  localparam logic [1:0] HOST_WRDIS = 2'b11;

  // device-side opcodes inside a frame
  localparam logic [1:0] DEV_OP_READ  = 2'b10;
  localparam logic [1:0] DEV_OP_WRITE = 2'b01;
  localparam logic [1:0] DEV_OP_CTL   = 2'b00;

  typedef enum logic [2:0] {
    STEP_EN, STEP_WR, STEP_POLL, STEP_DIS, STEP_RD, STEP_END
  } step_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SEND, S_RECV, S_POLL, S_GAP
  } state_e;

  function automatic step_e first_step(input logic [1:0] op);
    case (op)
      HOST_READ:  return STEP_RD;
      HOST_WRITE: return STEP_EN;
      HOST_WREN:  return STEP_EN;
      default:    return STEP_DIS;
    endcase
  endfunction

  function automatic step_e after_step(input step_e s, input logic [1:0] op);
    case (s)
      STEP_EN:   return (op == HOST_WRITE) ? STEP_WR : STEP_END;
      STEP_WR:   return STEP_POLL;
      STEP_POLL: return STEP_DIS;
      default:   return STEP_END;
    endcase
  endfunction

endpackage

// File: rtl/uw_phase_timer.sv
module uw_phase_timer #(
  parameter int PHASE_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_CLKS - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  AST_PHASE_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R3

endmodule

// File: rtl/uw_frame_gen.sv
module uw_frame_gen
  import uw_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int FRAME_W = 3 + ADDR_W + DATA_W,
  parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  step_e              step,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   len
);
  localparam int HDR_W = 3 + ADDR_W;

  always_comb begin
    frame = '0;
    len   = '0;
    case (step)
      STEP_EN: begin
        frame = {1'b1, DEV_OP_CTL, {ADDR_W{1'b1}}, {DATA_W{1'b0}}};
        len   = LEN_W'(HDR_W);
      end
      STEP_DIS: begin
        frame = {1'b1, DEV_OP_CTL, {ADDR_W{1'b0}}, {DATA_W{1'b0}}};
        len   = LEN_W'(HDR_W);
      end
      STEP_RD: begin
        frame = {1'b1, DEV_OP_READ, addr, {DATA_W{1'b0}}};
        len   = LEN_W'(HDR_W);
      end
      STEP_WR: begin
        frame = {1'b1, DEV_OP_WRITE, addr, wdata};
        len   = LEN_W'(FRAME_W);
      end
      default: begin
        frame = '0;
        len   = '0;
      end
    endcase
  end

endmodule

// File: rtl/uw_engine.sv
module uw_engine
  import uw_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int POLL_W  = 16,
  parameter int FRAME_W = 3 + ADDR_W + DATA_W,
  parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [DATA_W-1:0]  cmd_wdata,
  input  logic [POLL_W-1:0]  poll_limit,
  input  logic               tick,
  output logic               run,
  output step_e              fg_step,
  output logic [ADDR_W-1:0]  fg_addr,
  output logic [DATA_W-1:0]  fg_wdata,
  input  logic [FRAME_W-1:0] fg_frame,
  input  logic [LEN_W-1:0]   fg_len,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic [DATA_W-1:0]  rdata,
  output logic               mw_sel,
  output logic               mw_clk,
  output logic               mw_tx,
  input  logic               mw_rx
);
  localparam int RXC_W = $clog2(DATA_W + 1);

  state_e              state;
  step_e               step;
  logic [1:0]          op_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [POLL_W-1:0]   limit_q;
  logic [FRAME_W-1:0]  sh;
  logic [LEN_W-1:0]    bits_left;
  logic [1:0]          ph;
  logic [DATA_W-1:0]   rx;
  logic [RXC_W-1:0]    rx_left;
  logic [POLL_W-1:0]   poll_cnt;
  logic                fail_q;
  logic                poll_last;

  assign run      = (state != S_IDLE);
  assign fg_step  = (state == S_IDLE) ? first_step(cmd_op) : after_step(step, op_q);
  assign fg_addr  = (state == S_IDLE) ? cmd_addr  : addr_q;
  assign fg_wdata = (state == S_IDLE) ? cmd_wdata : wdata_q;

  // limit of zero behaves as one sample
  assign poll_last = ({1'b0, poll_cnt} + 1'b1) >= {1'b0, limit_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      step      <= STEP_END;
      op_q      <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      limit_q   <= '0;
      sh        <= '0;
      bits_left <= '0;
      ph        <= '0;
      rx        <= '0;
      rx_left   <= '0;
      poll_cnt  <= '0;
      fail_q    <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      rdata     <= '0;
      mw_sel    <= 1'b0;
      mw_clk    <= 1'b0;
      mw_tx     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (cmd_valid) begin
            op_q    <= cmd_op;
            addr_q  <= cmd_addr;
            wdata_q <= cmd_wdata;
            limit_q <= poll_limit;
            busy    <= 1'b1;
            err     <= 1'b0;
            fail_q  <= 1'b0;
            step    <= fg_step;
            state   <= S_SEND;
            sh      <= fg_frame;
            bits_left <= fg_len;
            ph      <= 2'd0;
            mw_sel  <= 1'b1;
            mw_clk  <= 1'b0;
            mw_tx   <= fg_frame[FRAME_W-1];
          end
        end

        S_SEND: begin
          if (tick) begin
            case (ph)
              2'd0: begin
                mw_clk <= 1'b1;
                ph     <= 2'd1;
              end
              2'd1: begin
                mw_clk <= 1'b0;
                ph     <= 2'd2;
              end
              default: begin
                if (bits_left != LEN_W'(1)) begin
                  sh        <= sh << 1;
                  mw_tx     <= sh[FRAME_W-2];
                  bits_left <= bits_left - 1'b1;
                  ph        <= 2'd0;
                end else if (step == STEP_RD) begin
                  state   <= S_RECV;
                  mw_clk  <= 1'b1;
                  mw_tx   <= 1'b0;
                  ph      <= 2'd0;
                  rx_left <= RXC_W'(DATA_W);
                end else begin
                  state  <= S_GAP;
                  mw_sel <= 1'b0;
                  mw_tx  <= 1'b0;
                end
              end
            endcase
          end
        end

        S_RECV: begin
          if (tick) begin
            if (ph == 2'd0) begin
              rx     <= {rx[DATA_W-2:0], mw_rx};
              mw_clk <= 1'b0;
              ph     <= 2'd1;
            end else if (rx_left != RXC_W'(1)) begin
              mw_clk  <= 1'b1;
              ph      <= 2'd0;
              rx_left <= rx_left - 1'b1;
            end else begin
              state  <= S_GAP;
              mw_sel <= 1'b0;
            end
          end
        end

        S_POLL: begin
          if (tick) begin
            if (mw_rx) begin
              state  <= S_GAP;
              mw_sel <= 1'b0;
            end else if (poll_last) begin
              fail_q <= 1'b1;
              state  <= S_GAP;
              mw_sel <= 1'b0;
            end else begin
              poll_cnt <= poll_cnt + 1'b1;
            end
          end
        end

        S_GAP: begin
          if (tick) begin
            step <= fg_step;
            if (fg_step == STEP_END) begin
              state <= S_IDLE;
              busy  <= 1'b0;
              done  <= 1'b1;
              err   <= fail_q;
              if (step == STEP_RD) rdata <= rx;
            end else if (fg_step == STEP_POLL) begin
              state    <= S_POLL;
              poll_cnt <= '0;
              mw_sel   <= 1'b1;
              mw_clk   <= 1'b0;
              mw_tx    <= 1'b0;
            end else begin
              state     <= S_SEND;
              sh        <= fg_frame;
              bits_left <= fg_len;
              ph        <= 2'd0;
              mw_sel    <= 1'b1;
              mw_clk    <= 1'b0;
              mw_tx     <= fg_frame[FRAME_W-1];
            end
          end
        end

        default: state <= S_IDLE;
      endcase
    end
  end

  AST_CLK_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
    mw_clk |-> mw_sel); // R3

  AST_CLK_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !$stable(mw_clk) |-> $past(tick)); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R2

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R2

  AST_IGNORE_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid) |=> $stable(addr_q)); // R2

  AST_GAP_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    (state == S_GAP) |-> (!mw_sel && !mw_clk)); // R5

  AST_POLL_CLOCK_LOW: assert property (@(posedge clk) disable iff (rst)
    (state == S_POLL) |-> (mw_sel && !mw_clk)); // R7

  AST_POLL_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (state == S_POLL) |-> ((poll_cnt < limit_q) || (poll_cnt == '0))); // R8

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> done); // R8

endmodule

// File: rtl/uwire_eeprom_master.sv
module uwire_eeprom_master
  import uw_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int POLL_W     = 16,
  parameter int PHASE_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [POLL_W-1:0] poll_limit,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic              mw_sel,
  output logic              mw_clk,
  output logic              mw_tx,
  input  logic              mw_rx
);
  localparam int FRAME_W = 3 + ADDR_W + DATA_W;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  logic               tick;
  logic               run;
  step_e              fg_step;
  logic [ADDR_W-1:0]  fg_addr;
  logic [DATA_W-1:0]  fg_wdata;
  logic [FRAME_W-1:0] fg_frame;
  logic [LEN_W-1:0]   fg_len;

  uw_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick)
  );

  uw_frame_gen #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W)
  ) u_frame (
    .step  (fg_step),
    .addr  (fg_addr),
    .wdata (fg_wdata),
    .frame (fg_frame),
    .len   (fg_len)
  );

  uw_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .POLL_W(POLL_W),
    .FRAME_W(FRAME_W), .LEN_W(LEN_W)
  ) u_engine (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_addr   (cmd_addr),
    .cmd_wdata  (cmd_wdata),
    .poll_limit (poll_limit),
    .tick       (tick),
    .run        (run),
    .fg_step    (fg_step),
    .fg_addr    (fg_addr),
    .fg_wdata   (fg_wdata),
    .fg_frame   (fg_frame),
    .fg_len     (fg_len),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .rdata      (rdata),
    .mw_sel     (mw_sel),
    .mw_clk     (mw_clk),
    .mw_tx      (mw_tx),
    .mw_rx      (mw_rx)
  );

endmodule

// File: tb/tb_uwire_eeprom_master.sv
`timescale 1ns/1ps
module tb_uwire_eeprom_master;
  localparam int P = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [7:0]  cmd_addr = 8'h00;
  logic [15:0] cmd_wdata = 16'h0;
  logic [15:0] poll_limit = 16'd100;
  logic        busy, done, err;
  logic [15:0] rdata;
  logic        mw_sel, mw_clk, mw_tx, mw_rx;

  always #5 clk = ~clk;

  uwire_eeprom_master #(.PHASE_CLKS(P)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .poll_limit(poll_limit),
    .busy(busy), .done(done), .err(err), .rdata(rdata),
    .mw_sel(mw_sel), .mw_clk(mw_clk), .mw_tx(mw_tx), .mw_rx(mw_rx)
  );

  // ---------------- device model ----------------
  logic [15:0] mem [256];
  logic [15:0] exp_mem [256];
  int          nb = 0;
  logic [31:0] shv = '0;
  logic [10:0] hdr = '0;
  logic        do_bit = 1'b0;
  bit          we = 1'b0;
  bit          pend = 1'b0;
  int          pc = 0;
  int          ready_after = 0;
  int          flen [16];
  logic [31:0] fval [16];
  int          fcnt = 0;

  assign mw_rx = (pend && mw_sel) ? (pc >= ready_after) : do_bit;

  always @(posedge mw_clk) if (mw_sel) begin
    shv = {shv[30:0], mw_tx};
    nb  = nb + 1;
    if (nb == 11) hdr = shv[10:0];
    if (nb >= 12 && nb <= 27 && hdr[9:8] == 2'b10)
      do_bit = mem[hdr[7:0]][15-(nb-12)];
  end

  always @(negedge mw_sel) begin
    if (fcnt < 16) begin
      flen[fcnt] = nb;
      fval[fcnt] = shv;
    end
    fcnt = fcnt + 1;
    if (nb == 27 && shv[25:24] == 2'b01) begin
      if (we) mem[shv[23:16]] = shv[15:0];
      pend = 1'b1;
    end else if (nb == 11 && shv[10:8] == 3'b100) begin
      if (shv[7:6] == 2'b11) we = 1'b1;
      else if (shv[7:6] == 2'b00) we = 1'b0;
    end else if (nb == 0) begin
      pend = 1'b0;
    end
    nb = 0; shv = '0; do_bit = 1'b0;
  end

  always @(posedge clk) pc <= (pend && mw_sel) ? pc + 1 : 0;

  // clock-high width monitor (R3)
  int hi = 0;
  int bad_clk = 0;
  always @(negedge clk) if (!rst) begin
    if (mw_clk) hi = hi + 1;
    else if (hi != 0) begin
      if (hi != P) bad_clk = bad_clk + 1;
      hi = 0;
    end
    if (mw_clk && !mw_sel) bad_clk = bad_clk + 1;
  end

  // ---------------- checking ----------------
  int n_vec = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  int  cyc;
  bit  busy1;
  int  extra_done;

  task automatic run_cmd(input logic [1:0] op, input logic [7:0] a,
                         input logic [15:0] d, input logic [15:0] lim,
                         input int inject_at);
    fcnt = 0;
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_wdata = d; poll_limit = lim;
    cmd_valid = 1'b1;
    cyc = 0; busy1 = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) busy1 = busy;
      if (cyc == inject_at) begin
        cmd_valid = 1'b1; cmd_op = 2'b00; cmd_addr = ~a;
      end else cmd_valid = 1'b0;
      if (done || cyc > 5000) break;
    end
  endtask

  function automatic int polls_for(input int r, input int lim);
    int k;
    int l;
    k = (r + 1 + P - 1) / P;
    l = (lim == 0) ? 1 : lim;
    return (k > l) ? l : k;
  endfunction

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 16'h0101) ^ 16'hA5C3 ^ (a << 3));
  endfunction

  task automatic check_write(input logic [7:0] a, input logic [15:0] d,
                             input int r, input int lim);
    int  k;
    bit  to;
    k  = polls_for(r, lim);
    to = ((r + 1 + P - 1) / P) > ((lim == 0) ? 1 : lim);
    ready_after = r;
    run_cmd(2'b01, a, d, 16'(lim), 0);
    chk(busy1, "R2", "busy after accept", busy1, 1);
    chk(cyc == (151 + k) * P + 1, "R9", "write done cycle", cyc, (151 + k) * P + 1);
    chk(err == to, to ? "R8" : "R10", "write err", err, to);
    chk(fcnt == 4, "R5", "write frame count", fcnt, 4);
    chk(flen[0] == 11 && fval[0] == 32'h4FF, "R6", "enable frame", fval[0], 32'h4FF);
    chk(flen[1] == 27 && fval[1] == {5'b0, 3'b101, a, d}, "R5", "write frame",
        fval[1], {5'b0, 3'b101, a, d});
    chk(flen[2] == 0, "R7", "poll has no clocks", flen[2], 0);
    chk(flen[3] == 11 && fval[3] == 32'h400, to ? "R8" : "R6", "disable frame",
        fval[3], 32'h400);
    exp_mem[a] = d;
  endtask

  task automatic check_read(input logic [7:0] a);
    ready_after = 0;
    run_cmd(2'b00, a, 16'h0, 16'd1, 0);
    chk(cyc == 66 * P + 1, "R9", "read done cycle", cyc, 66 * P + 1);
    chk(rdata == exp_mem[a], "R4", "read data", rdata, exp_mem[a]);
    chk(err == 1'b0, "R10", "read err", err, 0);
    chk(fcnt == 1 && flen[0] == 27 && fval[0] == {5'b0, 3'b110, a, 16'h0}, "R4",
        "read frame", fval[0], {5'b0, 3'b110, a, 16'h0});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 16'hFFFF; exp_mem[i] = 16'hFFFF; end
    repeat (4) @(negedge clk);
    chk(!mw_sel && !mw_clk && !mw_tx && !busy && !done && !err && rdata == 16'h0,
        "R1", "outputs in reset", {mw_sel, mw_clk, mw_tx, busy, done, err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!mw_sel && !busy && !done && rdata == 16'h0, "R1", "after reset",
        {mw_sel, busy, done}, 0);

    // unwritten location reads erased value
    check_read(8'h3C);

    // standalone enable / disable
    run_cmd(2'b10, 8'h00, 16'h0, 16'd1, 0);
    chk(cyc == 34 * P + 1, "R9", "enable done cycle", cyc, 34 * P + 1);
    chk(fcnt == 1 && flen[0] == 11 && fval[0] == 32'h4FF, "R6", "enable only",
        fval[0], 32'h4FF);
    chk(we == 1'b1, "R6", "device write-enabled", we, 1);
    run_cmd(2'b11, 8'h00, 16'h0, 16'd1, 0);
    chk(cyc == 34 * P + 1, "R9", "disable done cycle", cyc, 34 * P + 1);
    chk(fcnt == 1 && flen[0] == 11 && fval[0] == 32'h400, "R6", "disable only",
        fval[0], 32'h400);
    chk(we == 1'b0, "R6", "device write-disabled", we, 0);

    // ready at first sample, and write rdata untouched
    check_write(8'h00, 16'h1234, 0, 100);
    chk(rdata == 16'hFFFF, "R10", "rdata held over write", rdata, 16'hFFFF);
    check_read(8'h00);

    // near-exhaustive sweep with varying ready latency
    for (int a = 1; a < 256; a += 3) check_write(8'(a), pat(a), a % 11, 50);
    for (int a = 0; a < 256; a++) check_read(8'(a));

    // timeout with small limit, then zero limit
    check_write(8'h77, 16'hBEEF, 10000, 4);
    check_write(8'h78, 16'hCAFE, 10000, 0);
    chk(err == 1'b1, "R8", "err held after timeout", err, 1);
    check_read(8'h78);

    // request while busy is ignored
    ready_after = 2;
    run_cmd(2'b01, 8'h20, 16'h5A5A, 16'd50, 40);
    exp_mem[8'h20] = 16'h5A5A;
    chk(fcnt == 4, "R2", "no extra frames while busy", fcnt, 4);
    extra_done = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done || mw_sel) extra_done++;
    end
    chk(extra_done == 0, "R2", "ignored request stays silent", extra_done, 0);
    check_read(8'h20);

    chk(bad_clk == 0, "R3", "clock high width and select", bad_clk, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule